// File: doc/BRIEF.md
# EEPROM Write-Completion Toggle Poller

This block is a host-side controller for a parallel EEPROM bus. A command on the host side carries one address and one data byte. The block performs a single byte write cycle on the memory bus. It then works out when the device has finished its internal programming by reading the same location again and again. While the device is still busy, one data bit changes value on every read. The block compares that bit between each read and the one before it, and it declares the write complete at the first pair of reads that agree.

The poller never tests for a particular level of the watched bit. That level may start or finish at either value, so only equality between consecutive reads counts. No copy of the written value is needed to detect completion. All other data bits are ignored. A limit on the number of poll reads ends a write that never settles, and a timeout pulse reports it. The memory control lines are active low. The data bus comes with a separate output-enable, so that a tri-state buffer can be built at the chip boundary.

Top module: `eep_toggle_poller`

## Requirements
- R1: While reset is held and right after it, `busy_o`, `done_o`, `timeout_o` and `mem_dq_oe_o` are low, and `mem_ce_n_o`, `mem_oe_n_o` and `mem_we_n_o` are high.
- R2: An accepted start performs exactly one write. During that write `mem_we_n_o` is low for exactly `WR_PULSE` consecutive cycles, and for all of those cycles `mem_ce_n_o` is low, `mem_oe_n_o` is high, `mem_dq_oe_o` is high, `mem_addr_o` equals the captured address and `mem_dq_o` equals the captured data.
- R3: `mem_we_n_o` and `mem_oe_n_o` are never low in the same cycle, and `mem_dq_oe_o` is never high while `mem_oe_n_o` is low.
- R4: After `mem_we_n_o` returns high, the first poll read starts only after exactly `GAP_CYC` cycles in which chip enable, output enable and write enable are all high.
- R5: Each poll read holds `mem_ce_n_o` and `mem_oe_n_o` low for exactly `RD_WAIT` cycles with the data bus released. The data is sampled in the last of those cycles. Consecutive reads are separated by at least one cycle with `mem_oe_n_o` high. Every poll read uses the written address.
- R6: Completion is decided only by equality of data bit `TOG_BIT` (bit 6 by default) between a read and the read before it, at either level. `done_o` pulses after the first read whose bit equals that of the previous read. If the bit flips on the first T transitions between reads, the pulse follows read number T+2.
- R7: `done_o` is a one-cycle pulse that fires exactly once per transaction. `busy_o` goes low in the same cycle that `done_o` rises.
- R8: If read number `MAX_READS` still differs from its predecessor, `timeout_o` pulses for one cycle, `busy_o` falls with it, no further read is made, and `done_o` does not fire for that transaction.
- R9: `busy_o` is high from the cycle after an accepted start until completion or timeout. A start request while `busy_o` is high is ignored: it causes no extra write and does not change the address.
- R10: Data bits other than `TOG_BIT` have no effect on when completion or timeout is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| start_i | input | 1 | Request one write; accepted when idle |
| addr_i | input | AW | Target address, captured at accept |
| data_i | input | DW | Byte to write, captured at accept |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse: device reports write finished |
| timeout_o | output | 1 | One-cycle pulse: poll limit reached while still toggling |
| mem_addr_o | output | AW | Memory address bus |
| mem_dq_o | output | DW | Data driven toward memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | DW | Data returned by memory |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |

## Verification
`busy_o` is due one cycle after the accepting edge. Write enable falls one cycle later, after a single set-up cycle with chip enable low. The bench samples every output on the falling clock edge, so it always reads values that are already settled. A stub memory model counts the cycles it sees in each bus phase and compares them with `WR_PULSE`, `GAP_CYC` and `RD_WAIT`. The stub also counts its reads, advancing its read index on the edge where output enable returns high. `done_o` or `timeout_o` appear in the falling-edge sample right after the sampling edge of the deciding read. At that moment the stub's read count must equal T+2, or `MAX_READS` for a timeout. A few idle cycles are watched after each transaction, which confirms that no second pulse follows.

// File: rtl/eep_poll_pkg.sv
package eep_poll_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WSETUP,
    S_WPULSE,
    S_WHOLD,
    S_GAP,
    S_RD,
    S_RREC
  } seq_state_e;

  function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Timer preload so that a phase lasts exactly n cycles.
  function automatic int unsigned phase_preload(int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  // Extracts the watched bit by masking the whole word.
  function automatic logic pick_bit(logic [63:0] word, int unsigned pos);
    logic [63:0] mask;
    mask = 64'd1 << pos;
    return ^(word & mask);
  endfunction

  // Two samples of the watched bit agree: device finished.
  function automatic logic pair_settled(logic prev_b, logic cur_b);
    return ~(prev_b ^ cur_b);
  endfunction

endpackage

// File: rtl/eep_phase_timer.sv
module eep_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R5: phase lengths depend on a strict one-per-cycle countdown
  p_timer_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!load_i) && ($past(cnt_q) != '0)) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/eep_toggle_track.sv
module eep_toggle_track #(
  parameter int unsigned MAX_READS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic sample_i,
  input  logic sample_bit_i,
  output logic hit_o,
  output logic last_o
);
  import eep_poll_pkg::*;

  localparam int unsigned RCW = $clog2(MAX_READS + 1);

  logic           ref_bit_q;
  logic           have_ref_q;
  logic [RCW-1:0] rd_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_bit_q  <= 1'b0;
      have_ref_q <= 1'b0;
      rd_cnt_q   <= '0;
    end else if (clear_i) begin
      have_ref_q <= 1'b0;
      rd_cnt_q   <= '0;
    end else if (sample_i) begin
      ref_bit_q  <= sample_bit_i;
      have_ref_q <= 1'b1;
      rd_cnt_q   <= rd_cnt_q + 1'b1;
    end
  end

  assign hit_o  = sample_i && have_ref_q && pair_settled(ref_bit_q, sample_bit_i);
  assign last_o = sample_i && (rd_cnt_q == RCW'(MAX_READS - 1));

  // R8: the loop never runs past its read limit
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_q <= RCW'(MAX_READS));

  // R6: a match needs a reference taken by an earlier read
  p_hit_after_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (rd_cnt_q != '0));

endmodule

// File: rtl/eep_bus_seq.sv
module eep_bus_seq
  import eep_poll_pkg::*;
#(
  parameter int unsigned AW        = 15,
  parameter int unsigned DW        = 8,
  parameter int unsigned CW        = 4,
  parameter int unsigned WR_PULSE  = 3,
  parameter int unsigned RD_WAIT   = 2,
  parameter int unsigned GAP_CYC   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          trk_clear_o,
  output logic          trk_sample_o,
  input  logic          trk_hit_i,
  input  logic          trk_last_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  output logic          mem_ce_n_o,
  output logic          mem_oe_n_o,
  output logic          mem_we_n_o
);

  localparam logic [CW-1:0] WR_LOAD  = CW'(phase_preload(WR_PULSE));
  localparam logic [CW-1:0] RD_LOAD  = CW'(phase_preload(RD_WAIT));
  localparam logic [CW-1:0] GAP_LOAD = CW'(phase_preload(GAP_CYC));

  seq_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          busy_q, done_q, tout_q;

  // Named internal events
  logic accept_ev;
  logic sample_ev;
  logic finish_ev;
  logic expire_ev;

  assign accept_ev = (state_q == S_IDLE) && start_i;
  assign sample_ev = (state_q == S_RD) && tmr_zero_i;
  assign finish_ev = sample_ev && trk_hit_i;
  assign expire_ev = sample_ev && !trk_hit_i && trk_last_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tout_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept_ev) begin
          addr_q  <= addr_i;
          data_q  <= data_i;
          busy_q  <= 1'b1;
          state_q <= S_WSETUP;
        end
        S_WSETUP: state_q <= S_WPULSE;
        S_WPULSE: if (tmr_zero_i) state_q <= S_WHOLD;
        S_WHOLD:  state_q <= S_GAP;
        S_GAP:    if (tmr_zero_i) state_q <= S_RD;
        S_RD: if (sample_ev) begin
          if (finish_ev) begin
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= S_IDLE;
          end else if (expire_ev) begin
            tout_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_RREC;
          end
        end
        S_RREC:   state_q <= S_RD;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  // Phase timer control
  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      S_WSETUP: begin tmr_load_o = 1'b1; tmr_val_o = WR_LOAD;  end
      S_WHOLD:  begin tmr_load_o = 1'b1; tmr_val_o = GAP_LOAD; end
      S_GAP:    begin tmr_load_o = tmr_zero_i; tmr_val_o = RD_LOAD; end
      S_RREC:   begin tmr_load_o = 1'b1; tmr_val_o = RD_LOAD;  end
      default:  begin tmr_load_o = 1'b0; tmr_val_o = '0;       end
    endcase
  end

  assign trk_clear_o  = accept_ev;
  assign trk_sample_o = sample_ev;

  // Bus decode from the registered state
  always_comb begin
    mem_ce_n_o  = 1'b1;
    mem_oe_n_o  = 1'b1;
    mem_we_n_o  = 1'b1;
    mem_dq_oe_o = 1'b0;
    unique case (state_q)
      S_WSETUP, S_WHOLD: begin mem_ce_n_o = 1'b0; mem_dq_oe_o = 1'b1; end
      S_WPULSE: begin mem_ce_n_o = 1'b0; mem_we_n_o = 1'b0; mem_dq_oe_o = 1'b1; end
      S_RD:     begin mem_ce_n_o = 1'b0; mem_oe_n_o = 1'b0; end
      default:  begin end
    endcase
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = data_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign timeout_o  = tout_q;

  // R3: a write strobe and a read strobe never overlap
  p_we_oe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n_o && !mem_oe_n_o));

  // R3: no drive fight while the device outputs data
  p_no_contention_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n_o |-> !mem_dq_oe_o);

  // R2: write strobe only with chip selected, outputs off and data driven
  p_we_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> (!mem_ce_n_o && mem_oe_n_o && mem_dq_oe_o));

  // R7: completion ends the busy window and lasts one cycle
  p_done_drops_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: a transaction ends in completion or timeout, never both
  p_end_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));

  // R9: the transaction address cannot move while busy
  p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));

  // R5: a read always ends with the strobe released
  p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ev && !finish_ev && !expire_ev) |=> mem_oe_n_o);

endmodule

// File: rtl/eep_toggle_poller.sv
module eep_toggle_poller #(
  parameter int unsigned AW        = 15,
  parameter int unsigned DW        = 8,
  parameter int unsigned TOG_BIT   = 6,
  parameter int unsigned WR_PULSE  = 3,
  parameter int unsigned RD_WAIT   = 2,
  parameter int unsigned GAP_CYC   = 4,
  parameter int unsigned MAX_READS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_ce_n_o,
  output logic          mem_oe_n_o,
  output logic          mem_we_n_o
);
  import eep_poll_pkg::*;

  localparam int unsigned CW = $clog2(max_of3(WR_PULSE, RD_WAIT, GAP_CYC) + 1);

  logic          tmr_zero, tmr_load;
  logic [CW-1:0] tmr_val;
  logic          trk_clear, trk_sample, trk_hit, trk_last;
  logic          watched_bit;

  assign watched_bit = pick_bit(64'(mem_dq_i), TOG_BIT);

  eep_bus_seq #(
    .AW(AW), .DW(DW), .CW(CW),
    .WR_PULSE(WR_PULSE), .RD_WAIT(RD_WAIT), .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
    .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .trk_clear_o(trk_clear), .trk_sample_o(trk_sample),
    .trk_hit_i(trk_hit), .trk_last_i(trk_last),
    .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
    .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o), .mem_we_n_o(mem_we_n_o)
  );

  eep_phase_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  eep_toggle_track #(.MAX_READS(MAX_READS)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .clear_i(trk_clear), .sample_i(trk_sample), .sample_bit_i(watched_bit),
    .hit_o(trk_hit), .last_o(trk_last)
  );

  // R1: quiet bus and flags in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy_o && !done_o && !timeout_o && !mem_dq_oe_o &&
                mem_ce_n_o && mem_oe_n_o && mem_we_n_o));

endmodule

// File: tb/eep_toggle_poller_bench.sv
`timescale 1ns/1ps
module eep_toggle_poller_bench;

  localparam int AW = 15, DW = 8, TB6 = 6;
  localparam int WRP = 3, RDW = 2, GAPC = 4, MAXR = 16;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic busy, done, tout, dq_oe, ce_n, oe_n, we_n;
  logic [AW-1:0] maddr;
  logic [DW-1:0] dq_out, dq_in, stub_val;

  always #2 clk = ~clk;  // 250 MHz

  eep_toggle_poller #(
    .AW(AW), .DW(DW), .TOG_BIT(TB6), .WR_PULSE(WRP), .RD_WAIT(RDW),
    .GAP_CYC(GAPC), .MAX_READS(MAXR)
  ) u_eep_toggle_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .data_i(data),
    .busy_o(busy), .done_o(done), .timeout_o(tout),
    .mem_addr_o(maddr), .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in),
    .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n)
  );

  int checks = 0, errors = 0, cyc = 0;

  // Stub memory state
  int t_flips = 0;
  logic base6 = 1'b0;
  int rd_idx = 0;
  logic [DW-1:0] other_bits = '0;

  function automatic logic exp_bit(logic b, int k, int t);
    int m;
    m = (k < t) ? k : t;
    return b ^ m[0];
  endfunction

  always_comb begin
    stub_val = other_bits;
    stub_val[TB6] = exp_bit(base6, rd_idx, t_flips);
  end
  assign dq_in = (!ce_n && !oe_n) ? stub_val : '0;

  // Monitor state
  logic prev_we = 1'b1, prev_oe = 1'b1, in_gap = 1'b0, gap_done = 1'b0;
  int wr_cnt, we_len, gap_cnt, gap_seen, rd_len, bad_rd, bad_bus, bad_addr;
  int done_cnt, tout_cnt, reads_at_end;
  logic [AW-1:0] wr_addr, exp_addr;
  logic [DW-1:0] wr_data;

  task automatic mon_clear();
    wr_cnt = 0; we_len = 0; gap_cnt = 0; gap_seen = -1; rd_len = 0;
    bad_rd = 0; bad_bus = 0; bad_addr = 0; done_cnt = 0; tout_cnt = 0;
    reads_at_end = -1; in_gap = 1'b0; gap_done = 1'b0; rd_idx = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if ((!we_n && !oe_n) || (!oe_n && dq_oe) || (!we_n && (ce_n || !oe_n || !dq_oe)))
        bad_bus++;
      if (!we_n) begin
        we_len++; wr_addr = maddr; wr_data = dq_out;
      end
      if (we_n && !prev_we) begin
        wr_cnt++; in_gap = 1'b1; gap_cnt = 0;
      end
      if (in_gap && ce_n && oe_n && we_n) gap_cnt++;
      if (!oe_n) begin
        if (prev_oe && in_gap) begin in_gap = 1'b0; gap_seen = gap_cnt; end
        if (ce_n) bad_bus++;
        if (maddr != exp_addr) bad_addr++;
        rd_len++;
      end
      if (oe_n && !prev_oe) begin
        if (rd_len != RDW) bad_rd++;
        rd_len = 0;
        rd_idx++;
        other_bits = DW'($urandom);
      end
      if (done) begin done_cnt++; reads_at_end = rd_idx; end
      if (tout) begin tout_cnt++; reads_at_end = rd_idx; end
      prev_we = we_n;
      prev_oe = oe_n;
    end
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_txn(logic [AW-1:0] a, logic [DW-1:0] d, int t, logic b, bit inject);
    int n;
    @(negedge clk);
    mon_clear();
    t_flips = t; base6 = b; exp_addr = a;
    addr = a; data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    addr = ~a; data = ~d;
    chk(busy == 1'b1, "R9 busy one cycle after accept", int'(busy), 1);
    n = 0;
    while (!done && !tout && n < 2000) begin
      if (inject && n == 5) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(busy == 1'b0, "R7 busy low at end pulse", int'(busy), 0);
    repeat (6) @(negedge clk);
    chk(wr_cnt == 1, "R2 one write per start (R9 ignore)", wr_cnt, 1);
    chk(wr_addr == a, "R2 write address", int'(wr_addr), int'(a));
    chk(wr_data == d, "R2 write data", int'(wr_data), int'(d));
    chk(we_len == WRP, "R2 write pulse length", we_len, WRP);
    chk(bad_bus == 0, "R3 strobe overlap or contention", bad_bus, 0);
    chk(gap_seen == GAPC, "R4 idle gap before polling", gap_seen, GAPC);
    chk(bad_rd == 0, "R5 read strobe length", bad_rd, 0);
    chk(bad_addr == 0, "R5 R9 poll address", bad_addr, 0);
    if (t + 2 <= MAXR) begin
      // R6 R10: first matching pair is reads T+1 and T+2, other bits random
      chk(done_cnt == 1, "R7 done exactly once", done_cnt, 1);
      chk(tout_cnt == 0, "R8 no timeout when settled", tout_cnt, 0);
      chk(reads_at_end == t + 2, "R6 R10 reads before done", reads_at_end, t + 2);
    end else begin
      chk(tout_cnt == 1, "R8 timeout once", tout_cnt, 1);
      chk(done_cnt == 0, "R8 no done on timeout", done_cnt, 0);
      chk(reads_at_end == MAXR, "R8 reads at timeout", reads_at_end, MAXR);
    end
    chk(busy == 1'b0, "R9 idle after transaction", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'd1957));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !tout && !dq_oe, "R1 flags in reset", int'({busy, done, tout, dq_oe}), 0);
    chk(ce_n && oe_n && we_n, "R1 strobes high in reset", int'({ce_n, oe_n, we_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && ce_n && oe_n && we_n && !dq_oe, "R1 idle after reset", int'(busy), 0);

    // Directed corners
    run_txn(15'h1234, 8'hA5, 0, 1'b0, 1'b0);         // R6 settled at once
    run_txn(15'h0001, 8'h3C, 0, 1'b1, 1'b0);         // R6 other level
    run_txn(15'h7FFF, 8'h00, 1, 1'b1, 1'b1);         // R9 start while busy
    run_txn(15'h0400, 8'hFF, MAXR - 2, 1'b0, 1'b0);  // R8 match on last read
    run_txn(15'h2222, 8'h5A, MAXR - 1, 1'b1, 1'b0);  // R8 timeout boundary
    run_txn(15'h5555, 8'h81, MAXR + 3, 1'b0, 1'b1);  // R8 long toggle

    // Constrained random
    for (int i = 0; i < 24; i++) begin
      run_txn(AW'($urandom), DW'($urandom), int'($urandom % (MAXR + 2)),
              1'($urandom), 1'(($urandom % 3) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule